// File: doc/BRIEF.md
# Supply and Pushbutton Reset Generator

This block drives the processor reset line from two causes: a supply-good flag that another block has already digitized, and a raw, bouncing, active-low pushbutton. The pushbutton passes through a synchronizer and a stability filter before it counts as pressed or released. Whenever a cause is present, the reset is held. Once every cause has gone, a hold-off counter must run to its full length before the reset is let go. This ensures that every reset, whether from power-up, a supply dip or a button press, lasts at least a fixed minimum after its cause ends.

Both polarities come out as a pair, so no configuration choice is needed. Any other block that wants to force a reset, such as an early-warning interrupt or a watchdog status line, can be wired onto the pushbutton input. All timing constants are parameters counted in clock cycles. The default of 13,000,000 cycles gives 130 ms at 100 MHz. The block has no streaming data path: every pin is a plain level-sensitive control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `rg_reset_gen`

## Requirements
- R1: While `rst` is sampled high, and on the first clock edge after it, the reset is asserted: `cpu_rst_n` = 0 and `cpu_rst` = 1. After `rst` falls, the reset is released `HOLD_CYCLES` edges later if no cause is present.
- R2: When `supply_ok` is sampled low at a clock edge, the reset is asserted after that edge and stays asserted on every edge at which `supply_ok` is still low.
- R3: After the last cause ends, the reset deasserts exactly at the `HOLD_CYCLES`-th consecutive edge with no cause present. Once released, it stays released while no cause appears.
- R4: `btn_n` is brought through `SYNC_STAGES` flip-flops. A new level is accepted only after the synchronized value has differed from the accepted level for `DEB_CYCLES` consecutive edges, so a low pulse shorter than `DEB_CYCLES` cycles never produces a reset.
- R5: The level `btn_n` = 0 means pressed and 1 means released. An accepted press asserts the reset `SYNC_STAGES + DEB_CYCLES + 1` edges after `btn_n` first goes low.
- R6: The hold-off for a button starts only when the release is accepted. The reset deasserts `SYNC_STAGES + DEB_CYCLES + HOLD_CYCLES` edges after `btn_n` returns high, and it stays asserted for as long as the button is held, whatever the supply does.
- R7: A cause that appears while the hold-off is running stops the count. After the cause ends, the full `HOLD_CYCLES` count starts again from zero.
- R8: `cpu_rst` is always the complement of `cpu_rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous power-on reset of the block, active high |
| supply_ok | input | 1 | Digitized supply-in-tolerance flag, synchronous to `clk`, 1 = good |
| btn_n | input | 1 | Raw pushbutton or forced-reset request, active low, asynchronous |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rst | output | 1 | Processor reset, active high |

## Verification
The bench sweeps the length of a button low pulse from one cycle up to past the filter threshold. A filter that is off by one either lets a pulse one cycle too short trigger a reset, or misses a pulse that is exactly long enough. For each pulse length, the bench also checks the press latency and the release point to the cycle, which catches a hold-off that starts at the press instead of at the release. A supply dip is injected at every offset inside a running hold-off. A counter that carried on instead of restarting would release the reset early. Further cases cover a button held across a supply recovery and a block reset applied mid-operation; a design that let either cause end the reset too soon would release it while the other was still present.

// File: rtl/rg_pkg.sv
package rg_pkg;
  // Pushbutton line level after filtering.
  typedef enum logic {
    BTN_PRESSED  = 1'b0,
    BTN_RELEASED = 1'b1
  } btn_level_e;
endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= INIT;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rg_debounce.sv
module rg_debounce
  import rg_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  output btn_level_e state
);
  localparam int             CW   = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0]  LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BTN_RELEASED;
      run   <= '0;
    end else if (level == logic'(state)) begin
      run <= '0;
    end else if (run == LAST) begin
      state <= btn_level_e'(level);
      run   <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R4: a level change is accepted only at the end of a full differing run
  p_change_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state != $past(state)) |->
      ($past(run) == LAST && $past(level) != logic'($past(state))));
endmodule

// File: rtl/rg_hold.sv
module rg_hold #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic asserted
);
  localparam int            CW   = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst || cause) begin
      asserted <= 1'b1;
      quiet    <= '0;
    end else if (asserted) begin
      if (quiet == LAST) begin
        asserted <= 1'b0;
        quiet    <= '0;
      end else begin
        quiet <= quiet + 1'b1;
      end
    end
  end

  // R1: block reset always leaves the output asserted
  p_power_on_r1: assert property (@(posedge clk) rst |=> asserted);

  // R7: any cause keeps or re-arms the reset
  p_cause_holds_r7: assert property (@(posedge clk) disable iff (rst)
    cause |=> asserted);

  // R3: release happens only after a full quiet run with no cause
  p_release_after_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(asserted)) |-> ($past(quiet) == LAST && !$past(cause)));

  // R3: once released, stays released while no cause appears
  p_stays_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!asserted && !cause) |=> !asserted);
endmodule

// File: rtl/rg_reset_gen.sv
module rg_reset_gen
  import rg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 1_000_000,
  parameter int HOLD_CYCLES = 13_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic btn_n,
  output logic cpu_rst_n,
  output logic cpu_rst
);
  logic       btn_sync;
  btn_level_e btn_state;
  logic       cause;
  logic       held;

  rg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (btn_n),
    .q   (btn_sync)
  );

  rg_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst   (rst),
    .level (btn_sync),
    .state (btn_state)
  );

  assign cause = !supply_ok || (btn_state == BTN_PRESSED);

  rg_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .cause    (cause),
    .asserted (held)
  );

  assign cpu_rst   = held;
  assign cpu_rst_n = !held;

  // R2: a bad supply sampled at an edge asserts the reset after that edge
  p_supply_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !cpu_rst_n);
endmodule

// File: tb/sim_rg_reset_gen.sv
module sim_rg_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int S    = 2;
  localparam int DEB  = 3;
  localparam int HOLD = 12;
  localparam int WATCHDOG = 200_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic btn_n = 1'b1;
  logic cpu_rst_n, cpu_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rg_reset_gen #(.SYNC_STAGES(S), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) u0 (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .btn_n     (btn_n),
    .cpu_rst_n (cpu_rst_n),
    .cpu_rst   (cpu_rst)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_on);
    checks++;
    if (cpu_rst_n !== !exp_on || cpu_rst !== exp_on) begin
      fails++;
      $display("FAIL %s: cpu_rst_n=%b cpu_rst=%b expected cpu_rst_n=%b cpu_rst=%b (R8 pair)",
               req, cpu_rst_n, cpu_rst, !exp_on, exp_on);
    end
  endtask

  // Expect HOLD-1 asserted samples then release on the HOLD-th edge.
  task automatic expect_release(input string req);
    for (int k = 1; k <= HOLD; k++) begin
      tick(1);
      chk(req, k < HOLD);
    end
  endtask

  initial begin
    // R1: reset state
    tick(1);
    chk("R1", 1'b1);
    tick(2);
    chk("R1", 1'b1);
    rst = 1'b0;
    expect_release("R1");
    tick(3);
    chk("R3", 1'b0);

    // R2/R3: supply dips of several lengths
    for (int d = 1; d <= 4; d++) begin
      supply_ok = 1'b0;
      for (int i = 1; i <= d; i++) begin
        tick(1);
        chk("R2", 1'b1);
      end
      supply_ok = 1'b1;
      expect_release("R3");
      tick(2);
      chk("R3", 1'b0);
    end

    // R4/R5/R6: button pulse length sweep
    for (int l = 1; l <= DEB + 4; l++) begin
      int total;
      total = l + S + DEB + HOLD + 3;
      btn_n = 1'b0;
      for (int k = 1; k <= total; k++) begin
        logic e;
        tick(1);
        if (k == l) btn_n = 1'b1;
        e = (l >= DEB) && (k >= S + DEB + 1) && (k < l + S + DEB + HOLD);
        if (l < DEB)               chk("R4", e);
        else if (k <= S + DEB + 1) chk("R5", e);
        else                       chk("R6", e);
      end
    end

    // R7: supply dip at every offset inside a running hold-off
    for (int j = 1; j < HOLD; j++) begin
      supply_ok = 1'b0;
      tick(1);
      chk("R2", 1'b1);
      supply_ok = 1'b1;
      for (int i = 1; i <= j; i++) begin
        tick(1);
        chk("R7", 1'b1);
      end
      supply_ok = 1'b0;
      tick(1);
      chk("R7", 1'b1);
      supply_ok = 1'b1;
      expect_release("R7");
    end

    // R6: button held across a supply recovery
    btn_n = 1'b0;
    tick(S + DEB + 1);
    chk("R5", 1'b1);
    supply_ok = 1'b0;
    tick(2);
    chk("R2", 1'b1);
    supply_ok = 1'b1;
    for (int i = 1; i <= HOLD + 2; i++) begin
      tick(1);
      chk("R6", 1'b1);
    end
    btn_n = 1'b1;
    for (int k = 1; k <= S + DEB + HOLD; k++) begin
      tick(1);
      chk("R6", k < S + DEB + HOLD);
    end

    // R1: block reset mid-operation
    tick(2);
    chk("R3", 1'b0);
    rst = 1'b1;
    tick(1);
    chk("R1", 1'b1);
    rst = 1'b0;
    expect_release("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule